// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Register

This block holds the 32 sticky interrupt flags of a CAN FD protocol controller. Pulses and status levels arrive from the protocol engine, the receive and transmit handlers and the message-memory interface. Each one sets its own flag bit, and that bit stays set until the host clears it. Not every flag is a plain latch. The bus-off, error-warning and error-passive flags fire when their status level changes, whether it rises or falls. The two protocol-error flags fire only for a last-error code that reports a real error.

The host reads the flag word and enable word as plain outputs. A host write to the flag word clears every bit written as 1. A host write to the enable word replaces it. One interrupt output is asserted while any flag is set whose enable bit is also set.

A small mode machine turns two memory faults into controller mode changes. Its states are RUN, INIT and RESTRICTED. Its transitions are:
- T_UNC: any state to INIT on an uncorrected memory bit error.
- T_TXFAIL: RUN to RESTRICTED on a memory access failure reported by the transmit handler.
- T_INIT_REL: INIT to RUN when the host releases INIT.
- T_ASM_REL: RESTRICTED to RUN when the host clears the restricted-mode bit.

Every other input combination holds the current state.

Top module: `can_irq_flags`

## Requirements
- R1: After reset all flags are 0, the enable word is 0, the mode is RUN (ctl_init_o=0, ctl_asm_o=0) and irq_o is 0.
- R2: Flag bits 31 and 30 always read 0, whatever is written to them.
- R3: A one-cycle pulse sets its flag on the next clock edge, and the flag stays set. The pulse-to-flag mapping is:
  - rx_evt_i[7:0] sets bits 7:0.
  - tx_evt_i[7:0] sets bits 15:8.
  - tsw_i sets bit 16.
  - tmo_i sets bit 18.
  - drx_i sets bit 19.
  - elo_i sets bit 22.
  - wdi_i sets bit 26.
  - rsvd_acc_i sets bit 29.
- R4: A host write with host_sel_i=0 clears every flag whose bit in host_wdata_i is 1. Flags whose bit is 0 are left unchanged.
- R5: When a hardware set and a host clear hit the same bit in the same cycle, the bit ends up set.
- R6: Each of the following flags is set on any change of its level input, rising or falling:
  - bus_off_i sets bit 25.
  - err_warn_i sets bit 24.
  - err_pass_i sets bit 23.

  The reference level after reset is 0, and a level that holds steady sets nothing.
- R7: When nom_lec_upd_i is high and nom_lec_i is neither 0 nor 7, bit 27 is set. The same rule applies to dat_lec_upd_i and dat_lec_i for bit 28. Codes 0 and 7 set nothing.
- R8: ram_berr_i[1] sets bit 21 and moves the mode to INIT one cycle later (T_UNC). ram_berr_i[0] sets bit 20 and leaves the mode unchanged.
- R9: ram_fail_i sets bit 17. If ram_fail_tx_i is also high and the mode is RUN, the mode becomes RESTRICTED (T_TXFAIL). It stays there until host_asm_clr_i (T_ASM_REL).
- R10: irq_o is high exactly when some flag bit and the matching irq_en_o bit are both 1. A host write with host_sel_i=1 loads host_wdata_i into the enable word.
- R11: INIT is left only through host_init_clr_i (T_INIT_REL), and only when no uncorrected error arrives in the same cycle. A transmit-side failure while in INIT leaves the mode in INIT. T_UNC takes priority over T_ASM_REL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_evt_i | input | 8 | Receive FIFO event pulses (flags 7:0) |
| tx_evt_i | input | 8 | Transmit side event pulses (flags 15:8) |
| tsw_i | input | 1 | Timestamp wrap-around pulse |
| tmo_i | input | 1 | Timeout pulse |
| drx_i | input | 1 | Dedicated receive buffer stored pulse |
| elo_i | input | 1 | Error logging overflow pulse |
| wdi_i | input | 1 | Memory watchdog pulse |
| rsvd_acc_i | input | 1 | Reserved address access pulse |
| bus_off_i | input | 1 | Bus-off status level |
| err_warn_i | input | 1 | Error-warning status level |
| err_pass_i | input | 1 | Error-passive status level |
| nom_lec_upd_i | input | 1 | Nominal-phase error code update strobe |
| nom_lec_i | input | 3 | Nominal-phase last error code |
| dat_lec_upd_i | input | 1 | Data-phase error code update strobe |
| dat_lec_i | input | 3 | Data-phase last error code |
| ram_berr_i | input | 2 | Memory bit error: [1] uncorrected, [0] corrected |
| ram_fail_i | input | 1 | Memory access failure pulse |
| ram_fail_tx_i | input | 1 | Qualifies ram_fail_i as a transmit-handler failure |
| host_wr_i | input | 1 | Host write strobe |
| host_sel_i | input | 1 | Write target: 0 flag word (write-1-clear), 1 enable word |
| host_wdata_i | input | 32 | Host write data |
| host_init_clr_i | input | 1 | Host releases INIT mode |
| host_asm_clr_i | input | 1 | Host clears restricted mode |
| flags_o | output | 32 | Flag word |
| irq_en_o | output | 32 | Enable word |
| irq_o | output | 1 | Combined interrupt |
| ctl_init_o | output | 1 | Controller forced to initialization |
| ctl_asm_o | output | 1 | Controller in restricted operation |

## Verification
Several properties are checked on every cycle:
- The reserved bits stay zero.
- An active set always lands in the flag word, and it wins over a clear.
- A clear with no competing set always removes the bit.
- The qualified nominal error code sets bit 27.
- An uncorrected error forces INIT.
- INIT and RESTRICTED persist until their release.
- A zero enable word keeps the interrupt low.

Only the bench scenarios show the rest:
- The exact mapping of each pulse input to its bit.
- The either-direction firing of the error-state flags and their silence while a level holds.
- The rejection of codes 0 and 7.
- That a corrected error or a receive-side failure leaves the mode alone.
- The interrupt combining specific enable bits.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    localparam int FLAG_W   = 32;
    localparam int LEC_W    = 3;
    localparam int EVRX_W   = 8;
    localparam int EVTX_W   = 8;
    localparam int NUM_PH   = 2;
    localparam int NUM_EST  = 3;

    localparam int B_RX0    = 0;
    localparam int B_TX0    = 8;
    localparam int B_TSW    = 16;
    localparam int B_MRF    = 17;
    localparam int B_TOO    = 18;
    localparam int B_DRX    = 19;
    localparam int B_BECOR  = 20;
    localparam int B_BEUNC  = 21;
    localparam int B_ELO    = 22;
    localparam int B_EPAS   = 23;
    localparam int B_EWRN   = 24;
    localparam int B_BOFF   = 25;
    localparam int B_WDI    = 26;
    localparam int B_PERRN  = 27;
    localparam int B_PERRD  = 28;
    localparam int B_RSVACC = 29;

    localparam logic [FLAG_W-1:0] RSVD_MASK = 32'hC000_0000;

    typedef enum logic [1:0] {
        MODE_RUN        = 2'd0,
        MODE_INIT       = 2'd1,
        MODE_RESTRICTED = 2'd2
    } mode_e;

endpackage

// File: rtl/can_irq_stchg.sv
module can_irq_stchg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] chg_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign chg_o = lvl_i ^ prev_q;
endmodule

// File: rtl/can_irq_lecq.sv
module can_irq_lecq #(
    parameter int W = 3
) (
    input  logic         upd_i,
    input  logic [W-1:0] code_i,
    output logic         hit_o
);
    localparam logic [W-1:0] CODE_NONE   = '0;
    localparam logic [W-1:0] CODE_NOCHNG = '1;

    assign hit_o = upd_i && (code_i != CODE_NONE) && (code_i != CODE_NOCHNG);
endmodule

// File: rtl/can_irq_flagbank.sv
module can_irq_flagbank #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;
        logic bit_d;
        always_comb begin
            if (MASK[i]) bit_d = 1'b0;
            else         bit_d = set_i[i] | (bit_q & ~clr_i[i]);
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= bit_d;
        end
        assign q_o[i] = bit_q;
    end
endmodule

// File: rtl/can_irq_modefsm.sv
module can_irq_modefsm
    import can_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic unc_err_i,
    input  logic tx_fail_i,
    input  logic init_rel_i,
    input  logic asm_rel_i,
    output logic init_o,
    output logic asm_o
);
    mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_RUN: begin
                if (unc_err_i)      state_d = MODE_INIT;
                else if (tx_fail_i) state_d = MODE_RESTRICTED;
            end
            MODE_RESTRICTED: begin
                if (unc_err_i)      state_d = MODE_INIT;
                else if (asm_rel_i) state_d = MODE_RUN;
            end
            MODE_INIT: begin
                if (init_rel_i && !unc_err_i) state_d = MODE_RUN;
            end
            default: state_d = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        init_o = 1'b0;
        asm_o  = 1'b0;
        unique case (state_q)
            MODE_RUN:        ;
            MODE_INIT:       init_o = 1'b1;
            MODE_RESTRICTED: asm_o  = 1'b1;
            default:         ;
        endcase
    end
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
    import can_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVRX_W-1:0] rx_evt_i,
    input  logic [EVTX_W-1:0] tx_evt_i,
    input  logic              tsw_i,
    input  logic              tmo_i,
    input  logic              drx_i,
    input  logic              elo_i,
    input  logic              wdi_i,
    input  logic              rsvd_acc_i,
    input  logic              bus_off_i,
    input  logic              err_warn_i,
    input  logic              err_pass_i,
    input  logic              nom_lec_upd_i,
    input  logic [LEC_W-1:0]  nom_lec_i,
    input  logic              dat_lec_upd_i,
    input  logic [LEC_W-1:0]  dat_lec_i,
    input  logic [1:0]        ram_berr_i,
    input  logic              ram_fail_i,
    input  logic              ram_fail_tx_i,
    input  logic              host_wr_i,
    input  logic              host_sel_i,
    input  logic [FLAG_W-1:0] host_wdata_i,
    input  logic              host_init_clr_i,
    input  logic              host_asm_clr_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] irq_en_o,
    output logic              irq_o,
    output logic              ctl_init_o,
    output logic              ctl_asm_o
);
    logic [NUM_EST-1:0] est_chg;
    logic [NUM_PH-1:0]  pe_hit;
    logic [NUM_PH-1:0]  ph_upd;
    logic [LEC_W-1:0]   ph_code [NUM_PH];
    logic [FLAG_W-1:0]  set_vec;
    logic [FLAG_W-1:0]  clr_vec;
    logic [FLAG_W-1:0]  en_q;

    can_irq_stchg #(.N(NUM_EST)) u_stchg (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i ({bus_off_i, err_warn_i, err_pass_i}),
        .chg_o (est_chg)
    );

    assign ph_upd     = {dat_lec_upd_i, nom_lec_upd_i};
    assign ph_code[0] = nom_lec_i;
    assign ph_code[1] = dat_lec_i;

    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        can_irq_lecq #(.W(LEC_W)) u_lecq (
            .upd_i  (ph_upd[p]),
            .code_i (ph_code[p]),
            .hit_o  (pe_hit[p])
        );
    end

    always_comb begin
        set_vec = '0;
        set_vec[B_RX0 +: EVRX_W] = rx_evt_i;
        set_vec[B_TX0 +: EVTX_W] = tx_evt_i;
        set_vec[B_TSW]    = tsw_i;
        set_vec[B_MRF]    = ram_fail_i;
        set_vec[B_TOO]    = tmo_i;
        set_vec[B_DRX]    = drx_i;
        set_vec[B_BECOR]  = ram_berr_i[0];
        set_vec[B_BEUNC]  = ram_berr_i[1];
        set_vec[B_ELO]    = elo_i;
        set_vec[B_EPAS]   = est_chg[0];
        set_vec[B_EWRN]   = est_chg[1];
        set_vec[B_BOFF]   = est_chg[2];
        set_vec[B_WDI]    = wdi_i;
        set_vec[B_PERRN]  = pe_hit[0];
        set_vec[B_PERRD]  = pe_hit[1];
        set_vec[B_RSVACC] = rsvd_acc_i;
    end

    assign clr_vec = (host_wr_i && !host_sel_i) ? host_wdata_i : '0;

    can_irq_flagbank #(.W(FLAG_W), .MASK(RSVD_MASK)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .q_o   (flags_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       en_q <= '0;
        else if (host_wr_i && host_sel_i) en_q <= host_wdata_i;
    end

    assign irq_en_o = en_q;
    assign irq_o    = |(flags_o & en_q);

    can_irq_modefsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .unc_err_i  (ram_berr_i[1]),
        .tx_fail_i  (ram_fail_i && ram_fail_tx_i),
        .init_rel_i (host_init_clr_i),
        .asm_rel_i  (host_asm_clr_i),
        .init_o     (ctl_init_o),
        .asm_o      (ctl_asm_o)
    );
endmodule

// File: rtl/can_irq_flags_chk.sv
module can_irq_flags_chk
    import can_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [FLAG_W-1:0] flags_o,
    input logic [FLAG_W-1:0] irq_en_o,
    input logic              irq_o,
    input logic              ctl_init_o,
    input logic              ctl_asm_o,
    input logic [FLAG_W-1:0] set_vec,
    input logic [FLAG_W-1:0] clr_vec,
    input logic [1:0]        ram_berr_i,
    input logic              host_init_clr_i,
    input logic              host_asm_clr_i,
    input logic              nom_lec_upd_i,
    input logic [LEC_W-1:0]  nom_lec_i
);
    logic [FLAG_W-1:0] live_set;
    assign live_set = set_vec & ~RSVD_MASK;

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[31:30] == 2'b00);

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|live_set) |=> ((flags_o & $past(live_set)) == $past(live_set)));

    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((flags_o & $past(clr_vec & ~set_vec)) == '0));

    p_pea_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nom_lec_upd_i && nom_lec_i != 3'd0 && nom_lec_i != 3'd7) |=> flags_o[B_PERRN]);

    p_unc_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_berr_i[1] |=> (ctl_init_o && flags_o[B_BEUNC]));

    p_asm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_asm_o && !host_asm_clr_i && !ram_berr_i[1]) |=> ctl_asm_o);

    p_init_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_init_o && !host_init_clr_i) |=> ctl_init_o);

    p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_o == '0) |-> !irq_o);
endmodule

bind can_irq_flags can_irq_flags_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .flags_o         (flags_o),
    .irq_en_o        (irq_en_o),
    .irq_o           (irq_o),
    .ctl_init_o      (ctl_init_o),
    .ctl_asm_o       (ctl_asm_o),
    .set_vec         (set_vec),
    .clr_vec         (clr_vec),
    .ram_berr_i      (ram_berr_i),
    .host_init_clr_i (host_init_clr_i),
    .host_asm_clr_i  (host_asm_clr_i),
    .nom_lec_upd_i   (nom_lec_upd_i),
    .nom_lec_i       (nom_lec_i)
);

// File: tb/can_irq_flags_test.sv
module can_irq_flags_test;
    logic clk = 1'b0;
    logic rst_n;
    logic [7:0]  rx_evt, tx_evt;
    logic tsw, tmo, drx, elo, wdi, rsvd_acc;
    logic bus_off, err_warn, err_pass;
    logic nom_upd, dat_upd;
    logic [2:0]  nom_lec, dat_lec;
    logic [1:0]  berr;
    logic ram_fail, ram_fail_tx;
    logic host_wr, host_sel, init_clr, asm_clr;
    logic [31:0] wdata;
    logic [31:0] flags, en;
    logic irq, c_init, c_asm;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    can_irq_flags uut (
        .clk(clk), .rst_n(rst_n), .rx_evt_i(rx_evt), .tx_evt_i(tx_evt),
        .tsw_i(tsw), .tmo_i(tmo), .drx_i(drx), .elo_i(elo), .wdi_i(wdi),
        .rsvd_acc_i(rsvd_acc), .bus_off_i(bus_off), .err_warn_i(err_warn),
        .err_pass_i(err_pass), .nom_lec_upd_i(nom_upd), .nom_lec_i(nom_lec),
        .dat_lec_upd_i(dat_upd), .dat_lec_i(dat_lec), .ram_berr_i(berr),
        .ram_fail_i(ram_fail), .ram_fail_tx_i(ram_fail_tx), .host_wr_i(host_wr),
        .host_sel_i(host_sel), .host_wdata_i(wdata), .host_init_clr_i(init_clr),
        .host_asm_clr_i(asm_clr), .flags_o(flags), .irq_en_o(en), .irq_o(irq),
        .ctl_init_o(c_init), .ctl_asm_o(c_asm)
    );

    // {rx[7:0], tx[7:0], misc[5:0] = {rsvd29,wdi26,elo22,drx19,too18,tsw16}, clr[31:0], exp[31:0]}
    localparam int NV = 15;
    localparam logic [85:0] VEC [NV] = '{
        {8'h01, 8'h00, 6'b000000, 32'h0000_0000, 32'h0000_0001},
        {8'h80, 8'h01, 6'b000000, 32'h0000_0000, 32'h0000_0181},
        {8'h00, 8'h80, 6'b000000, 32'h0000_0000, 32'h0000_8181},
        {8'h00, 8'h00, 6'b000001, 32'h0000_0000, 32'h0001_8181},
        {8'h00, 8'h00, 6'b000010, 32'h0000_0000, 32'h0005_8181},
        {8'h00, 8'h00, 6'b000100, 32'h0000_0000, 32'h000D_8181},
        {8'h00, 8'h00, 6'b001000, 32'h0000_0000, 32'h004D_8181},
        {8'h00, 8'h00, 6'b010000, 32'h0000_0000, 32'h044D_8181},
        {8'h00, 8'h00, 6'b100000, 32'h0000_0000, 32'h244D_8181},
        {8'h00, 8'h00, 6'b000000, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h02, 8'h00, 6'b000000, 32'h0000_0002, 32'h0000_0002},
        {8'h00, 8'h00, 6'b000000, 32'h0000_0001, 32'h0000_0002},
        {8'h00, 8'h10, 6'b000000, 32'h0000_0002, 32'h0000_1000},
        {8'h00, 8'h00, 6'b000000, 32'hC000_0000, 32'h0000_1000},
        {8'h00, 8'h00, 6'b000000, 32'h0000_1000, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_pulses();
        rx_evt = '0; tx_evt = '0; tsw = 0; tmo = 0; drx = 0; elo = 0; wdi = 0;
        rsvd_acc = 0; nom_upd = 0; dat_upd = 0; berr = '0; ram_fail = 0;
        ram_fail_tx = 0; host_wr = 0; host_sel = 0; wdata = '0;
        init_clr = 0; asm_clr = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle_pulses();
    endtask

    task automatic clear_all();
        host_wr = 1; host_sel = 0; wdata = 32'hFFFF_FFFF;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; idle_pulses();
        bus_off = 0; err_warn = 0; err_pass = 0; nom_lec = '0; dat_lec = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 flags", flags, 32'h0);
        chk("R1 enable", en, 32'h0);
        chk("R1 mode", {30'b0, c_init, c_asm}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R3 R4 R5 table walk
        for (int i = 0; i < NV; i++) begin
            rx_evt = VEC[i][85:78]; tx_evt = VEC[i][77:70];
            {rsvd_acc, wdi, elo, drx, tmo, tsw} = VEC[i][69:64];
            if (VEC[i][63:32] != 0) begin
                host_wr = 1; host_sel = 0; wdata = VEC[i][63:32];
            end
            tick();
            chk("R3/R4/R5 vector", flags, VEC[i][31:0]);
        end

        // R2 reserved bits ignore writes
        host_wr = 1; host_sel = 0; wdata = 32'h0;
        tick();
        chk("R2 reserved", flags & 32'hC000_0000, 32'h0);

        // R7 LEC qualification
        nom_upd = 1; nom_lec = 3'd0; tick();
        chk("R7 code0", flags, 32'h0);
        nom_upd = 1; nom_lec = 3'd7; tick();
        chk("R7 code7", flags, 32'h0);
        nom_upd = 1; nom_lec = 3'd3; tick();
        chk("R7 nominal", flags, 32'h0800_0000);
        dat_upd = 1; dat_lec = 3'd7; tick();
        chk("R7 data code7", flags, 32'h0800_0000);
        dat_upd = 1; dat_lec = 3'd5; tick();
        chk("R7 data", flags, 32'h1800_0000);
        clear_all();

        // R6 error-state change detection
        bus_off = 1; tick();
        chk("R6 bus-off rise", flags, 32'h0200_0000);
        clear_all();
        tick();
        chk("R6 steady", flags, 32'h0);
        bus_off = 0; tick();
        chk("R6 bus-off fall", flags, 32'h0200_0000);
        clear_all();
        err_warn = 1; tick();
        chk("R6 warning", flags, 32'h0100_0000);
        clear_all();
        err_pass = 1; tick();
        chk("R6 passive", flags, 32'h0080_0000);
        err_warn = 0; err_pass = 0; tick();
        chk("R6 both fall", flags, 32'h0180_0000);
        clear_all();

        // R8 memory bit errors
        berr = 2'b01; tick();
        chk("R8 corrected flag", flags, 32'h0010_0000);
        chk("R8 corrected mode", {30'b0, c_init, c_asm}, 32'h0);
        berr = 2'b10; tick();
        chk("R8 uncorrected flag", flags, 32'h0030_0000);
        chk("R8 init", {31'b0, c_init}, 32'h1);
        // R11 tx fail while INIT stays INIT
        ram_fail = 1; ram_fail_tx = 1; tick();
        chk("R11 init holds", {30'b0, c_init, c_asm}, 32'h2);
        init_clr = 1; tick();
        chk("R11 init release", {30'b0, c_init, c_asm}, 32'h0);
        clear_all();

        // R9 access failures
        ram_fail = 1; tick();
        chk("R9 rx-side fail", flags, 32'h0002_0000);
        chk("R9 rx-side mode", {30'b0, c_init, c_asm}, 32'h0);
        ram_fail = 1; ram_fail_tx = 1; tick();
        chk("R9 restricted", {31'b0, c_asm}, 32'h1);
        tick(); tick(); init_clr = 1; tick();
        chk("R9 restricted holds", {31'b0, c_asm}, 32'h1);
        asm_clr = 1; tick();
        chk("R9 release", {30'b0, c_init, c_asm}, 32'h0);
        ram_fail = 1; ram_fail_tx = 1; tick();
        berr = 2'b10; asm_clr = 1; tick();
        chk("R11 unc over release", {30'b0, c_init, c_asm}, 32'h2);
        init_clr = 1; tick();
        clear_all();

        // R10 interrupt combining
        rx_evt = 8'h04; tick();
        chk("R10 disabled", {31'b0, irq}, 32'h0);
        host_wr = 1; host_sel = 1; wdata = 32'h0000_0008; tick();
        chk("R10 enable word", en, 32'h0000_0008);
        chk("R10 other bit", {31'b0, irq}, 32'h0);
        chk("R10 flags untouched by enable write", flags, 32'h0000_0004);
        host_wr = 1; host_sel = 1; wdata = 32'h0000_000C; tick();
        chk("R10 enabled", {31'b0, irq}, 32'h1);
        host_wr = 1; host_sel = 0; wdata = 32'h0000_0004; tick();
        chk("R10 cleared", {31'b0, irq}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule